// File: doc/BRIEF.md
# External Interrupt Pin Latch

This block turns an active-low external interrupt pin into a pending request for the interrupt controller. The pin is first brought into the clock domain by a short synchronizer chain. A falling edge on the synchronized pin sets a request latch. The core pulses a clear strobe while it reads the vector for this interrupt, so the latch empties early in interrupt entry. A falling edge that arrives while the handler is still running is therefore captured, and it is serviced as soon as the core clears its mask bit again.

A configuration input picks one of two trigger modes. In edge-only mode only falling edges request service. In edge-and-level mode, a pin that is still low also keeps the request up. This mode suits several open-drain sources that share one pin: any source that still holds the line low after a handler returns causes another interrupt. The block also provides a wake signal, taken from the synchronized pin-low condition, which brings the device out of stop mode.

Top module: `ext_irq_cond`

## Requirements
- R1: After reset, with the pin high, both `irq_req_o` and `wake_o` are 0.
- R2: With `mode_level_i`=0 (edge-only), a falling edge on `irq_pin_n_i` makes `irq_req_o` go to 1 three clock edges after the pin changes, provided `mask_i`=0.
- R3: A latched request stays pending after the pin returns high, until a clear strobe arrives.
- R4: A one-cycle `vec_clr_i` pulse empties the latch. In edge-only mode with the pin high, `irq_req_o` reads 0 after that edge.
- R5: A falling edge that is detected in the same cycle as `vec_clr_i` is kept, and the request stays pending.
- R6: While `mask_i`=1, `irq_req_o` is 0. The latched request is not lost, and it shows again as soon as `mask_i` returns to 0.
- R7: In edge-only mode, a pin that is held low does not raise a second request once the latch has been cleared.
- R8: With `mode_level_i`=1 (edge-and-level), a low pin drives `irq_req_o` to 1 two clock edges after the pin falls, and it stays 1 across clear strobes for as long as the pin stays low.
- R9: `wake_o` is 1 exactly when the pin, as sampled two clock edges earlier, is low. Mask and mode have no effect on it.
- R10: A rising edge on the pin never sets the request latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n_i | input | 1 | External interrupt pin, active low, asynchronous |
| mode_level_i | input | 1 | 0 = edge-only trigger, 1 = edge-and-level trigger |
| vec_clr_i | input | 1 | One-cycle strobe from the core during the vector read; empties the latch |
| mask_i | input | 1 | Interrupt mask bit from the core; 1 hides the request |
| irq_req_o | output | 1 | Pending, unmasked interrupt request |
| wake_o | output | 1 | Synchronized pin-low indication used to leave stop mode |

## Verification
The directed cases cover four situations:
- A short low pulse tells edge capture apart from level following, because the request must outlive the pulse in edge-only mode.
- A pin held low across a clear strobe tells the two modes apart: edge-only mode stays quiet and edge-and-level mode re-requests.
- A clear strobe placed on the very cycle a falling edge is detected checks that the new edge wins.
- Toggling the mask shows that a hidden request is kept and is not dropped.

After these, random pin activity with slow and fast toggling, random mode changes, random clear strobes and random masking is compared each cycle against a cycle-accurate model. This exposes off-by-one latencies on the request and on the wake signal.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    typedef enum logic {
        TRIG_EDGE_ONLY  = 1'b0,
        TRIG_EDGE_LEVEL = 1'b1
    } trig_mode_e;

    typedef struct packed {
        logic prev_hi;   // synchronized pin value one cycle earlier
        logic pend;      // request latch
    } edge_state_t;

    typedef struct packed {
        logic req;
        logic wake;
    } merge_out_t;

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int   STAGES    = 2,
    parameter logic IDLE_LVL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic pin_s_o
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = pin_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.chain <= {STAGES{IDLE_LVL}};
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_s_o = st_q.chain[LAST];

    // the final stage only ever takes the previous stage's value
    AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pin_s_o == $past(st_q.chain[LAST-1])));  // R9

endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch
    import ext_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s_i,
    input  logic clr_i,
    output logic pend_o,
    output logic fall_o
);
    edge_state_t st_d, st_q;
    logic        fall;

    always_comb begin
        st_d         = st_q;
        fall         = st_q.prev_hi & ~pin_s_i;
        st_d.prev_hi = pin_s_i;
        // a fresh edge wins over a simultaneous clear
        st_d.pend    = (st_q.pend & ~clr_i) | fall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev_hi <= 1'b1;
            st_q.pend    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign fall_o = fall;

    AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> pend_o);                                    // R2
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !clr_i) |=> pend_o);                        // R3
    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !fall_o) |=> !pend_o);                       // R4
    AST_CLR_EDGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && fall_o) |=> pend_o);                         // R5
    AST_RISE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_o && pin_s_i) |=> !pend_o);                     // R10

endmodule

// File: rtl/irq_req_merge.sv
module irq_req_merge
    import ext_irq_pkg::*;
(
    input  logic       pend_i,
    input  logic       pin_s_i,
    input  trig_mode_e mode_i,
    input  logic       mask_i,
    output logic       req_o,
    output logic       wake_o
);
    merge_out_t out_d;
    logic       raw_req;

    always_comb begin
        out_d   = '0;
        raw_req = pend_i;
        if (mode_i == TRIG_EDGE_LEVEL) begin
            raw_req = pend_i | ~pin_s_i;
        end
        out_d.req  = raw_req & ~mask_i;
        out_d.wake = ~pin_s_i;
    end

    assign req_o  = out_d.req;
    assign wake_o = out_d.wake;

endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond
    import ext_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_pin_n_i,
    input  logic mode_level_i,
    input  logic vec_clr_i,
    input  logic mask_i,
    output logic irq_req_o,
    output logic wake_o
);
    localparam int STAGES_USED = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    logic       pin_s;
    logic       pend;
    logic       fall;
    trig_mode_e mode;

    assign mode = trig_mode_e'(mode_level_i);

    irq_pin_sync #(
        .STAGES   (STAGES_USED),
        .IDLE_LVL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (irq_pin_n_i),
        .pin_s_o (pin_s)
    );

    irq_edge_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_s_i (pin_s),
        .clr_i   (vec_clr_i),
        .pend_o  (pend),
        .fall_o  (fall)
    );

    irq_req_merge u_merge (
        .pend_i  (pend),
        .pin_s_i (pin_s),
        .mode_i  (mode),
        .mask_i  (mask_i),
        .req_o   (irq_req_o),
        .wake_o  (wake_o)
    );

    AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        mask_i |-> !irq_req_o);                                        // R6
    AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_level_i && wake_o && !mask_i) |-> irq_req_o);            // R8
    AST_EDGE_ONLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_level_i && !pend && !mask_i) |-> !irq_req_o);           // R7
    AST_FALL_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> wake_o);                                              // R9

endmodule

// File: tb/ext_irq_cond_tb.sv
`timescale 1ns/1ps
module ext_irq_cond_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_n = 1'b1;
    logic mode_lvl = 1'b0;
    logic clr = 1'b0;
    logic mask = 1'b0;
    logic irq_req;
    logic wake;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // requirement-level model state
    logic m_s1, m_s2, m_prev, m_latch;

    always #2.5 clk = ~clk;

    ext_irq_cond dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_pin_n_i  (pin_n),
        .mode_level_i (mode_lvl),
        .vec_clr_i    (clr),
        .mask_i       (mask),
        .irq_req_o    (irq_req),
        .wake_o       (wake)
    );

    function automatic logic exp_req();
        return (m_latch | (mode_lvl & ~m_s2)) & ~mask;
    endfunction

    function automatic logic exp_wake();
        return ~m_s2;
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_s1 = 1'b1; m_s2 = 1'b1; m_prev = 1'b1; m_latch = 1'b0;
    endtask

    // drive inputs, take one clock edge, return at the falling edge
    task automatic tick(input logic p, input logic md, input logic c, input logic mk);
        logic f;
        pin_n = p; mode_lvl = md; clr = c; mask = mk;
        @(posedge clk);
        f       = m_prev & ~m_s2;
        m_latch = (m_latch & ~c) | f;
        m_prev  = m_s2;
        m_s2    = m_s1;
        m_s1    = p;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 req", irq_req, 1'b0);
        chk("R1 wake", wake, 1'b0);

        // edge-only pulse
        tick(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R9 wake one edge", wake, 1'b0);
        tick(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R9 wake two edges", wake, 1'b1);
        chk("R2 req not yet", irq_req, 1'b0);
        tick(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R2 req three edges", irq_req, 1'b1);
        repeat (3) tick(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R3 held after pulse", irq_req, 1'b1);
        tick(1'b1, 1'b0, 1'b1, 1'b0);
        chk("R4 cleared", irq_req, 1'b0);

        // held low in edge-only mode
        repeat (4) tick(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R2 held low", irq_req, 1'b1);
        tick(1'b0, 1'b0, 1'b1, 1'b0);
        repeat (3) tick(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R7 no re-request", irq_req, 1'b0);
        repeat (4) tick(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R10 rise no set", irq_req, 1'b0);

        // clear coinciding with detected edge
        tick(1'b0, 1'b0, 1'b0, 1'b0);
        tick(1'b0, 1'b0, 1'b0, 1'b0);
        tick(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R5 edge beats clear", irq_req, 1'b1);

        // mask
        tick(1'b1, 1'b0, 1'b0, 1'b1);
        chk("R6 masked", irq_req, 1'b0);
        chk("R9 wake under mask", wake, 1'b1);
        repeat (3) tick(1'b1, 1'b0, 1'b0, 1'b1);
        tick(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R6 unmasked again", irq_req, 1'b1);
        tick(1'b1, 1'b0, 1'b1, 1'b0);
        repeat (2) tick(1'b1, 1'b0, 1'b0, 1'b0);

        // level mode
        tick(1'b0, 1'b1, 1'b0, 1'b0);
        tick(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R8 level two edges", irq_req, 1'b1);
        tick(1'b0, 1'b1, 1'b1, 1'b0);
        tick(1'b0, 1'b1, 1'b1, 1'b0);
        chk("R8 survives clear", irq_req, 1'b1);
        repeat (3) tick(1'b1, 1'b1, 1'b0, 1'b0);
        tick(1'b1, 1'b1, 1'b1, 1'b0);
        chk("R8 released", irq_req, 1'b0);

        // random phase checked against the model
        for (int i = 0; i < 6000; i++) begin
            logic p, md, c, mk;
            int   rate;
            rate = (i < 3000) ? 8 : 2;
            p  = (($urandom % rate) == 0) ? ~pin_n : pin_n;
            md = (($urandom % 64) == 0) ? ~mode_lvl : mode_lvl;
            c  = (($urandom % 6) == 0);
            mk = (($urandom % 5) == 0);
            tick(p, md, c, mk);
            if (mk)
                chk("R6 random", irq_req, exp_req());
            else if (md)
                chk("R8 random", irq_req, exp_req());
            else
                chk("R2 random", irq_req, exp_req());
            chk("R9 random", wake, exp_wake());
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule